// File: doc/BRIEF.md
# JTAG Test Access Port with Memory Access Path

This block is a serial test access port clocked by the test clock. A test host steers it with the mode-select and data-in pins and reads results on the data-out pin. A standard sixteen-state controller sequences capture, shift and update operations. A 5-bit instruction register then chooses which data register is placed between data-in and data-out. Besides the usual bypass, identification and user code registers, three 8-bit registers give the host a byte-wide path into an attached memory. One holds the address, one holds the data to store, and one captures the byte read back.

Loading either of two dedicated opcodes into the instruction register fires a single-cycle command strobe, one meaning "save" and the other meaning "reboot", for logic outside the block. The memory side is a plain port: an address, write data with a one-cycle write strobe, and read data. The surrounding logic is expected to return the read data combinationally for the presented address. Reset is synchronous and active high, and every output comes from a register.

Top module: `jtag_mem_tap`

## Requirements
- R1: After reset the controller is in Test-Logic-Reset, tdo, mem_we, save_pulse and reboot_pulse are 0, mem_addr is 0, and the instruction register holds the identification opcode 00001.
- R2: Five consecutive rising edges of tck with tms high bring the controller to Test-Logic-Reset from any state, and that state reloads the identification opcode.
- R3: State transitions follow the standard sixteen-state graph. For example, from Run-Test/Idle, tms sequence 1,1,1 passes through Select-DR-Scan and Select-IR-Scan into Test-Logic-Reset, and Capture-DR is always followed by Shift-DR or Exit1-DR.
- R4: Capture-IR loads the pattern 00001 into the instruction shift register, so the first five bits shifted out of tdo during Shift-IR are 1,0,0,0,0.
- R5: Opcodes 00000, 00010, 11111, 01100, 01101 and every code not listed in R6 to R9 select a 1-bit bypass register that captures 0. An N-bit stream therefore returns 0 followed by the input delayed by one bit.
- R6: Opcode 00001 selects a 32-bit identification register that captures ID_VALUE, and opcode 00100 selects a 32-bit user code register that captures USER_VALUE. Both are shifted out least significant bit first.
- R7: Opcode 01000 selects the 8-bit address register. Capture-DR loads the current mem_addr, and Update-DR makes the shifted byte the new mem_addr.
- R8: Opcode 01001 selects the 8-bit write register, which does not parallel-load in Capture-DR. Leaving Update-DR raises mem_we for exactly one tck cycle, with mem_wdata equal to the shifted byte and mem_addr equal to the current address.
- R9: Opcode 01010 selects the 8-bit read register, which captures mem_rdata at the current address in Capture-DR. Its Update-DR produces no write.
- R10: Completing Update-IR with opcode 01100 raises save_pulse, and with 01101 raises reboot_pulse, each for exactly one tck cycle. Any other opcode raises neither, and the two pulses never overlap.
- R11: tdo changes only on the falling edge of tck, carries the selected register's least significant bit in Shift-DR or Shift-IR, and is 0 in every other state.
- R12: Pause-DR and the Exit states halt shifting. A Shift-DR split by a pause and resumed through Exit2-DR delivers the same data as an unbroken shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, updated on falling tck |
| mem_addr | output | ADDR_W | Current memory address |
| mem_wdata | output | DATA_W | Data for a memory write |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_rdata | input | DATA_W | Memory data at mem_addr |
| save_pulse | output | 1 | One-cycle save command strobe |
| reboot_pulse | output | 1 | One-cycle reboot command strobe |

## Verification
A bit shifted out is valid on tdo from the falling edge of tck in Shift-DR or Shift-IR and holds through the following rising edge. The bench therefore drives tms and tdi just after a falling edge, reads tdo at that same moment, and confirms after each rising edge that tdo has not moved. mem_we and the save and reboot strobes are set on the rising edge that leaves the matching Update state. The bench reads them just after that edge and again one edge later to confirm that each lasts a single cycle. Capture values appear on tdo at the first falling edge in Shift-DR, so the opcode sweep and the memory sweep compare whole shifted-out words against values derived arithmetically from the stimulus.

// File: rtl/jtm_pkg.sv
`timescale 1ns/1ps
package jtm_pkg;
  localparam int IR_W = 5;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
  } tap_state_t;

  typedef enum logic [2:0] {
    DR_BYPASS, DR_IDENT, DR_USER, DR_ADDR, DR_WRITE, DR_READ
  } dr_sel_t;

  localparam logic [IR_W-1:0] OP_IDENT   = 5'b00001;
  localparam logic [IR_W-1:0] OP_USER    = 5'b00100;
  localparam logic [IR_W-1:0] OP_ADDR    = 5'b01000;
  localparam logic [IR_W-1:0] OP_WRITE   = 5'b01001;
  localparam logic [IR_W-1:0] OP_READ    = 5'b01010;
  localparam logic [IR_W-1:0] OP_SAVE    = 5'b01100;
  localparam logic [IR_W-1:0] OP_REBOOT  = 5'b01101;
  localparam logic [IR_W-1:0] IR_CAP_PAT = 5'b00001;
endpackage

// File: rtl/jtm_fsm.sv
`timescale 1ns/1ps
module jtm_fsm
  import jtm_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t nxt;

  always_comb begin
    case (state)
      ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: nxt = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   nxt = tms ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: nxt = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
      ST_IR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
      default:     nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= ST_RESET;
    else     state <= nxt;
  end

  // Run of consecutive tms-high edges, kept only for the check below.
  logic [2:0] ones_run;
  always_ff @(posedge tck) begin
    if (rst)                    ones_run <= 3'd5;
    else if (!tms)              ones_run <= 3'd0;
    else if (ones_run != 3'd5)  ones_run <= ones_run + 3'd1;
  end

  // R2
  five_ones_reset_chk: assert property (@(posedge tck) disable iff (rst)
    (ones_run == 3'd5) |-> (state == ST_RESET));

  // R3
  cap_dr_next_chk: assert property (@(posedge tck) disable iff (rst)
    (state == ST_DR_CAP) |=> (state == ST_DR_SHIFT || state == ST_DR_EXIT1));

  // R3
  pause_hold_chk: assert property (@(posedge tck) disable iff (rst)
    (state == ST_DR_PAUSE && !tms) |=> (state == ST_DR_PAUSE));
endmodule

// File: rtl/jtm_ir.sv
`timescale 1ns/1ps
module jtm_ir
  import jtm_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  tap_state_t state,
  input  logic       tdi,
  output logic       ir_tdo,
  output dr_sel_t    dr_sel,
  output logic       save_pulse,
  output logic       reboot_pulse
);
  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_sr        <= IR_CAP_PAT;
      ir_q         <= OP_IDENT;
      save_pulse   <= 1'b0;
      reboot_pulse <= 1'b0;
    end else begin
      save_pulse   <= 1'b0;
      reboot_pulse <= 1'b0;
      case (state)
        ST_RESET:    ir_q  <= OP_IDENT;
        ST_IR_CAP:   ir_sr <= IR_CAP_PAT;
        ST_IR_SHIFT: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        ST_IR_UPD: begin
          ir_q         <= ir_sr;
          save_pulse   <= (ir_sr == OP_SAVE);
          reboot_pulse <= (ir_sr == OP_REBOOT);
        end
        default: ;
      endcase
    end
  end

  assign ir_tdo = ir_sr[0];

  always_comb begin
    case (ir_q)
      OP_IDENT: dr_sel = DR_IDENT;
      OP_USER:  dr_sel = DR_USER;
      OP_ADDR:  dr_sel = DR_ADDR;
      OP_WRITE: dr_sel = DR_WRITE;
      OP_READ:  dr_sel = DR_READ;
      default:  dr_sel = DR_BYPASS;
    endcase
  end

  // R10
  strobe_excl_chk: assert property (@(posedge tck) disable iff (rst)
    $onehot0({save_pulse, reboot_pulse}));

  // R10
  save_single_chk: assert property (@(posedge tck) disable iff (rst)
    save_pulse |=> !save_pulse);

  // R10
  reboot_single_chk: assert property (@(posedge tck) disable iff (rst)
    reboot_pulse |=> !reboot_pulse);

  // R4
  ir_capture_chk: assert property (@(posedge tck) disable iff (rst)
    (state == ST_IR_CAP) |=> (ir_sr == IR_CAP_PAT));
endmodule

// File: rtl/jtm_shreg.sv
`timescale 1ns/1ps
module jtm_shreg #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         rst,
  input  logic         cap_en,
  input  logic [W-1:0] cap_val,
  input  logic         sh_en,
  input  logic         tdi,
  output logic [W-1:0] q
);
  generate
    if (W == 1) begin : g_single
      always_ff @(posedge tck) begin
        if (rst)         q <= '0;
        else if (cap_en) q <= cap_val;
        else if (sh_en)  q <= tdi;
      end
    end else begin : g_chain
      always_ff @(posedge tck) begin
        if (rst)         q <= '0;
        else if (cap_en) q <= cap_val;
        else if (sh_en)  q <= {tdi, q[W-1:1]};
      end
    end
  endgenerate
endmodule

// File: rtl/jtag_mem_tap.sv
`timescale 1ns/1ps
module jtag_mem_tap
  import jtm_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter int              DATA_W     = 8,
  parameter int              ID_W       = 32,
  parameter logic [ID_W-1:0] ID_VALUE   = 32'h2B7D_40E3,
  parameter logic [ID_W-1:0] USER_VALUE = 32'h0C0F_FEE5
) (
  input  logic              tck,
  input  logic              rst,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              save_pulse,
  output logic              reboot_pulse
);
  tap_state_t state;
  dr_sel_t    dr_sel;
  logic       ir_tdo;

  jtm_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (state)
  );

  jtm_ir u_ir (
    .tck          (tck),
    .rst          (rst),
    .state        (state),
    .tdi          (tdi),
    .ir_tdo       (ir_tdo),
    .dr_sel       (dr_sel),
    .save_pulse   (save_pulse),
    .reboot_pulse (reboot_pulse)
  );

  logic cap_dr, sh_dr, upd_dr;
  assign cap_dr = (state == ST_DR_CAP);
  assign sh_dr  = (state == ST_DR_SHIFT);
  assign upd_dr = (state == ST_DR_UPD);

  logic [0:0]        byp_q;
  logic [ID_W-1:0]   id_q;
  logic [ID_W-1:0]   usr_q;
  logic [ADDR_W-1:0] adr_q;
  logic [DATA_W-1:0] wr_q;
  logic [DATA_W-1:0] rd_q;
  logic [ADDR_W-1:0] addr_r;
  logic [DATA_W-1:0] wdata_r;
  logic              we_r;

  jtm_shreg #(.W(1)) u_byp (
    .tck (tck), .rst (rst),
    .cap_en (cap_dr && dr_sel == DR_BYPASS), .cap_val (1'b0),
    .sh_en  (sh_dr  && dr_sel == DR_BYPASS), .tdi (tdi), .q (byp_q)
  );

  jtm_shreg #(.W(ID_W)) u_id (
    .tck (tck), .rst (rst),
    .cap_en (cap_dr && dr_sel == DR_IDENT), .cap_val (ID_VALUE),
    .sh_en  (sh_dr  && dr_sel == DR_IDENT), .tdi (tdi), .q (id_q)
  );

  jtm_shreg #(.W(ID_W)) u_usr (
    .tck (tck), .rst (rst),
    .cap_en (cap_dr && dr_sel == DR_USER), .cap_val (USER_VALUE),
    .sh_en  (sh_dr  && dr_sel == DR_USER), .tdi (tdi), .q (usr_q)
  );

  jtm_shreg #(.W(ADDR_W)) u_adr (
    .tck (tck), .rst (rst),
    .cap_en (cap_dr && dr_sel == DR_ADDR), .cap_val (addr_r),
    .sh_en  (sh_dr  && dr_sel == DR_ADDR), .tdi (tdi), .q (adr_q)
  );

  // The write register has no parallel load: its capture enable is tied off.
  jtm_shreg #(.W(DATA_W)) u_wr (
    .tck (tck), .rst (rst),
    .cap_en (1'b0), .cap_val ('0),
    .sh_en  (sh_dr && dr_sel == DR_WRITE), .tdi (tdi), .q (wr_q)
  );

  jtm_shreg #(.W(DATA_W)) u_rd (
    .tck (tck), .rst (rst),
    .cap_en (cap_dr && dr_sel == DR_READ), .cap_val (mem_rdata),
    .sh_en  (sh_dr  && dr_sel == DR_READ), .tdi (tdi), .q (rd_q)
  );

  // Memory-side registers
  always_ff @(posedge tck) begin
    if (rst) begin
      addr_r  <= '0;
      wdata_r <= '0;
      we_r    <= 1'b0;
    end else begin
      we_r <= upd_dr && (dr_sel == DR_WRITE);
      if (upd_dr && dr_sel == DR_ADDR)  addr_r  <= adr_q;
      if (upd_dr && dr_sel == DR_WRITE) wdata_r <= wr_q;
    end
  end

  assign mem_addr  = addr_r;
  assign mem_wdata = wdata_r;
  assign mem_we    = we_r;

  // Serial output select and falling-edge retiming
  logic dr_bit;
  always_comb begin
    case (dr_sel)
      DR_IDENT: dr_bit = id_q[0];
      DR_USER:  dr_bit = usr_q[0];
      DR_ADDR:  dr_bit = adr_q[0];
      DR_WRITE: dr_bit = wr_q[0];
      DR_READ:  dr_bit = rd_q[0];
      default:  dr_bit = byp_q[0];
    endcase
  end

  logic tdo_r;
  always_ff @(negedge tck) begin
    if (rst) tdo_r <= 1'b0;
    else begin
      case (state)
        ST_DR_SHIFT: tdo_r <= dr_bit;
        ST_IR_SHIFT: tdo_r <= ir_tdo;
        default:     tdo_r <= 1'b0;
      endcase
    end
  end
  assign tdo = tdo_r;

  // R11
  tdo_quiet_chk: assert property (@(posedge tck) disable iff (rst)
    tdo |-> (state == ST_DR_SHIFT || state == ST_IR_SHIFT));

  // R8
  we_single_chk: assert property (@(posedge tck) disable iff (rst)
    mem_we |=> !mem_we);

  // R8
  we_data_chk: assert property (@(posedge tck) disable iff (rst)
    mem_we |-> (mem_wdata == wr_q));

  // R7
  addr_update_chk: assert property (@(posedge tck) disable iff (rst)
    (upd_dr && dr_sel == DR_ADDR) |=> (mem_addr == $past(adr_q)));

  // R6
  ident_capture_chk: assert property (@(posedge tck) disable iff (rst)
    (cap_dr && dr_sel == DR_IDENT) |=> (id_q == ID_VALUE));

  // R6
  user_capture_chk: assert property (@(posedge tck) disable iff (rst)
    (cap_dr && dr_sel == DR_USER) |=> (usr_q == USER_VALUE));

  // R9
  read_capture_chk: assert property (@(posedge tck) disable iff (rst)
    (cap_dr && dr_sel == DR_READ) |=> (rd_q == $past(mem_rdata)));
endmodule

// File: tb/tb_jtag_mem_tap.sv
`timescale 1ns/1ps
module tb_jtag_mem_tap;
  localparam logic [31:0] ID_V  = 32'h2B7D_40E3;
  localparam logic [31:0] USR_V = 32'h0C0F_FEE5;

  logic       tck = 1'b0;
  logic       rst = 1'b1;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic       tdo;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we, save_pulse, reboot_pulse;

  int total = 0;
  int bad = 0;
  int hold_bad = 0;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];

  always #5 tck = ~tck;

  jtag_mem_tap #(.ID_VALUE(ID_V), .USER_VALUE(USR_V)) dut (
    .tck (tck), .rst (rst), .tms (tms), .tdi (tdi), .tdo (tdo),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_we (mem_we),
    .mem_rdata (mem_rdata), .save_pulse (save_pulse), .reboot_pulse (reboot_pulse)
  );

  always @(posedge tck) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
  end
  assign mem_rdata = mem[mem_addr];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One tck cycle: drive after the falling edge, read tdo there, then pass the rising edge.
  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    tms = m; tdi = d; o = tdo;
    @(posedge tck); #1;
    if (tdo !== o) hold_bad++;
  endtask

  task automatic shift_ir(input logic [4:0] op, output logic [4:0] cap,
                          output logic sv, output logic rb);
    logic o;
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, op[i], o);
      cap[i] = o;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    sv = save_pulse;
    rb = reboot_pulse;
  endtask

  task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout,
                          output logic we, output logic [7:0] wa, output logic [7:0] wd);
    logic o;
    dout = '0;
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      dout[i] = o;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    we = mem_we;
    wa = mem_addr;
    wd = mem_wdata;
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [4:0]  c;
    logic        sv, rb, we, o;
    logic [7:0]  wa, wd, prev_addr, prev_wr, pat, a, v;

    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    repeat (3) @(posedge tck);
    #1 rst = 1'b0;

    // R1 reset state
    check(tdo == 1'b0, "R1 tdo", {31'd0, tdo}, 32'd0);
    check(mem_we == 1'b0, "R1 mem_we", {31'd0, mem_we}, 32'd0);
    check({save_pulse, reboot_pulse} == 2'b00, "R1 strobes",
          {30'd0, save_pulse, reboot_pulse}, 32'd0);
    check(mem_addr == 8'h00, "R1 mem_addr", {24'd0, mem_addr}, 32'd0);

    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    check(o == 1'b0, "R11 idle tdo", {31'd0, o}, 32'd0);

    // R1 / R6 identification selected straight after reset
    shift_dr(32, 32'hFFFF_0000, d, we, wa, wd);
    check(d == ID_V, "R1 R6 ident after reset", d, ID_V);

    // R6 user code
    shift_ir(5'b00100, c, sv, rb);
    check(c == 5'b00001, "R4 capture pattern", {27'd0, c}, 32'd1);
    shift_dr(32, 32'h0, d, we, wa, wd);
    check(d == USR_V, "R6 user code", d, USR_V);

    // R5 / R4 / R10 sweep over every opcode
    for (int op = 0; op < 32; op++) begin
      shift_ir(op[4:0], c, sv, rb);
      check(c == 5'b00001, "R4 capture pattern", {27'd0, c}, 32'd1);
      check(sv == (op == 12), "R10 save pulse", {31'd0, sv}, {31'd0, op == 12});
      check(rb == (op == 13), "R10 reboot pulse", {31'd0, rb}, {31'd0, op == 13});
      step(1'b0, 1'b0, o);
      check({save_pulse, reboot_pulse} == 2'b00, "R10 single cycle",
            {30'd0, save_pulse, reboot_pulse}, 32'd0);
      if (!(op inside {1, 4, 8, 9, 10})) begin
        pat = 8'(op * 37 + 5);
        shift_dr(8, {24'd0, pat}, d, we, wa, wd);
        check(d[7:0] == {pat[6:0], 1'b0}, "R5 bypass", d, {24'd0, pat[6:0], 1'b0});
      end
    end

    // R7 / R8 write sweep
    prev_addr = 8'h00;
    prev_wr   = 8'h00;
    for (int k = 0; k < 8; k++) begin
      a = 8'(k * 29 + 3);
      v = 8'(k * 53 + 17);
      shift_ir(5'b01000, c, sv, rb);
      shift_dr(8, {24'd0, a}, d, we, wa, wd);
      check(d[7:0] == prev_addr, "R7 address capture", d, {24'd0, prev_addr});
      check(wa == a, "R7 address update", {24'd0, wa}, {24'd0, a});
      check(we == 1'b0, "R7 no write", {31'd0, we}, 32'd0);
      shift_ir(5'b01001, c, sv, rb);
      shift_dr(8, {24'd0, v}, d, we, wa, wd);
      check(d[7:0] == prev_wr, "R8 write register holds", d, {24'd0, prev_wr});
      check(we == 1'b1, "R8 write strobe", {31'd0, we}, 32'd1);
      check(wa == a, "R8 write address", {24'd0, wa}, {24'd0, a});
      check(wd == v, "R8 write data", {24'd0, wd}, {24'd0, v});
      step(1'b0, 1'b0, o);
      check(mem_we == 1'b0, "R8 strobe one cycle", {31'd0, mem_we}, 32'd0);
      exp_mem[a] = v;
      prev_addr  = a;
      prev_wr    = v;
    end

    // R9 read back, including one unwritten location
    for (int k = 0; k < 9; k++) begin
      a = (k == 8) ? 8'hF0 : 8'(k * 29 + 3);
      shift_ir(5'b01000, c, sv, rb);
      shift_dr(8, {24'd0, a}, d, we, wa, wd);
      shift_ir(5'b01010, c, sv, rb);
      shift_dr(8, 32'hFF, d, we, wa, wd);
      check(d[7:0] == exp_mem[a], "R9 read data", d, {24'd0, exp_mem[a]});
      check(we == 1'b0, "R9 read makes no write", {31'd0, we}, 32'd0);
    end
    prev_addr = 8'hF0;

    // R12 shift broken by Pause-DR
    shift_ir(5'b01000, c, sv, rb);
    d = '0;
    pat = 8'hC3;
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, pat[i], o);
      d[i] = o;
    end
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    check(o == 1'b0, "R11 tdo quiet in pause", {31'd0, o}, 32'd0);
    step(1'b0, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 3; i < 8; i++) begin
      step(i == 7, pat[i], o);
      d[i] = o;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    check(d[7:0] == prev_addr, "R12 paused shift out", d, {24'd0, prev_addr});
    check(mem_addr == pat, "R12 paused shift in", {24'd0, mem_addr}, {24'd0, pat});

    // R3 RTI -> Select-DR -> Select-IR -> Test-Logic-Reset
    shift_ir(5'b00100, c, sv, rb);
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    shift_dr(32, 32'h0, d, we, wa, wd);
    check(d == ID_V, "R3 path to reset", d, ID_V);

    // R2 five tms-high edges from the middle of Shift-DR
    shift_ir(5'b00100, c, sv, rb);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b1, o);
    step(1'b0, 1'b1, o);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    shift_dr(32, 32'h0, d, we, wa, wd);
    check(d == ID_V, "R2 tms reset reloads ident", d, ID_V);

    // R11 tdo held from falling edge through rising edge
    check(hold_bad == 0, "R11 tdo falling-edge timing", hold_bad, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule